// File: doc/BRIEF.md
# Burst Lane Address Sequencer

This block generates the address for each beat of a short burst. A start address is loaded once. Each later advance moves the low lane bits to the next position in a group of four. The upper address bits stay as loaded for the whole burst. Two orders are available: a linear order that counts the lane bits up and wraps, and an interleaved order that combines the start lane with a beat count through XOR.

The block also records the access direction (write or read) at the moment of the load. It keeps that direction on its output until the next load, whatever the direction input does in between. A stall input freezes all state. The order select is sampled at the load, so a burst keeps one order from start to end. The block is meant to sit between a command decoder and a memory array, and it feeds the array with one address per beat.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) sets the address output to all zeros and the direction output to 0 (read).
- R2: With stall low, load high at a clock edge makes addr_o equal start_addr after that edge and restarts the beat count at zero. load takes priority over step when both are high.
- R3: wr_in is captured into wr_o only at a load (1 = write, 0 = read). During steps wr_o keeps the captured value whatever wr_in does.
- R4: When the burst was loaded with mode_il = 0 (linear), each step adds one to addr_o[1:0] modulo 4. For example, start lane 1 gives 1, 2, 3, 0.
- R5: When the burst was loaded with mode_il = 1 (interleaved), addr_o[1:0] equals the start lane XOR the beat count 0, 1, 2, 3. For example, start lane 1 gives 1, 0, 3, 2.
- R6: After four beats, further steps keep cycling through the same four lanes, so the fifth beat returns to the start lane. Steps never change addr_o above bit 1.
- R7: With stall high at an edge, addr_o and wr_o keep their values, whatever load and step are doing.
- R8: With stall low and both load and step low, addr_o and wr_o hold.
- R9: mode_il is sampled only at a load. Changing it during a burst does not change the order of that burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Freezes all state when high |
| load | input | 1 | Loads start_addr, wr_in and mode_il and starts a burst |
| step | input | 1 | Advances to the next beat of the burst |
| start_addr | input | ADDR_W (32) | Start address of a burst |
| wr_in | input | 1 | Access direction to capture at a load (1 = write) |
| mode_il | input | 1 | Burst order captured at a load (0 = linear, 1 = interleaved) |
| addr_o | output | ADDR_W (32) | Address of the current beat |
| wr_o | output | 1 | Direction captured at the last load |

## Verification
The bench drives bursts whose beats run past four, in both orders and from several start lanes. A design that carried into bit 2, or that stopped at the last beat, would show a wrong upper address or a stuck lane. It toggles wr_in and mode_il in the middle of bursts. A design that followed them live would flip the direction or switch order partway through. It also asserts stall together with load and step, asserts load and step in the same cycle, and resets in the middle of a burst. These cases catch a freeze that only gates one of the controls, a step that wins over a reload, and a reset that leaves the stored lane or direction behind.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
   typedef enum logic {
      ORD_LINEAR = 1'b0,
      ORD_XOR    = 1'b1
   } order_e;
endpackage

// File: rtl/burst_step_count.sv
// Beat counter: cleared at a load, incremented at an accepted step.
module burst_step_count #(
   parameter int CW = 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          clr,
   input  logic          inc,
   output logic [CW-1:0] cnt
);
   localparam logic [CW-1:0] ONE = CW'(1);

   always_ff @(posedge clk) begin
      if (rst)      cnt <= '0;
      else if (clr) cnt <= '0;
      else if (inc) cnt <= cnt + ONE;
   end
endmodule

// File: rtl/burst_ctx_hold.sv
// Holds the burst context captured at a load: upper bits, start lane, type, order.
module burst_ctx_hold
   import burst_seq_pkg::*;
#(
   parameter int AW = 32,
   parameter int CW = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             capture,
   input  logic [AW-1:CW]   base_in,
   input  logic [CW-1:0]    lane_in,
   input  logic             wr_in,
   input  order_e           ord_in,
   output logic [AW-1:CW]   base_q,
   output logic [CW-1:0]    lane_q,
   output logic             wr_q,
   output order_e           ord_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         base_q <= '0;
         lane_q <= '0;
         wr_q   <= 1'b0;
         ord_q  <= ORD_LINEAR;
      end else if (capture) begin
         base_q <= base_in;
         lane_q <= lane_in;
         wr_q   <= wr_in;
         ord_q  <= ord_in;
      end
   end
endmodule

// File: rtl/burst_lane_map.sv
// Maps start lane and beat count onto the current lane in the selected order.
module burst_lane_map
   import burst_seq_pkg::*;
#(
   parameter int CW        = 2,
   parameter bit ALLOW_XOR = 1'b1
) (
   input  logic [CW-1:0] start_lane,
   input  logic [CW-1:0] cnt,
   input  order_e        ord,
   output logic [CW-1:0] lane
);
   logic [CW-1:0] lin_lane;

   assign lin_lane = start_lane + cnt;

   generate
      if (ALLOW_XOR) begin : g_both
         logic [CW-1:0] xor_lane;
         assign xor_lane = start_lane ^ cnt;
         assign lane = (ord == ORD_XOR) ? xor_lane : lin_lane;
      end else begin : g_lin
         logic unused_ord;
         assign unused_ord = ord;
         assign lane = lin_lane;
      end
   endgenerate
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
   import burst_seq_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int LANE_W    = 2,
   parameter bit ALLOW_XOR = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              stall,
   input  logic              load,
   input  logic              step,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic              wr_in,
   input  logic              mode_il,
   output logic [ADDR_W-1:0] addr_o,
   output logic              wr_o
);
   generate
      if (LANE_W < 1 || LANE_W >= ADDR_W) begin : g_bad_lane
         $error("burst_addr_seq: LANE_W must be at least 1 and below ADDR_W");
      end
   endgenerate

   logic              go;
   logic              do_load;
   logic              do_step;
   order_e            ord_sel;
   order_e            ord_q;
   logic [LANE_W-1:0] cnt;
   logic [LANE_W-1:0] lane_q;
   logic [LANE_W-1:0] lane;
   logic [ADDR_W-1:LANE_W] base_q;

   assign go      = !stall;
   assign do_load = go && load;
   assign do_step = go && !load && step;

   generate
      if (ALLOW_XOR) begin : g_ord_live
         assign ord_sel = mode_il ? ORD_XOR : ORD_LINEAR;
      end else begin : g_ord_fixed
         logic unused_mode;
         assign unused_mode = mode_il;
         assign ord_sel = ORD_LINEAR;
      end
   endgenerate

   burst_step_count #(.CW(LANE_W)) u_cnt (
      .clk (clk),
      .rst (rst),
      .clr (do_load),
      .inc (do_step),
      .cnt (cnt)
   );

   burst_ctx_hold #(.AW(ADDR_W), .CW(LANE_W)) u_ctx (
      .clk     (clk),
      .rst     (rst),
      .capture (do_load),
      .base_in (start_addr[ADDR_W-1:LANE_W]),
      .lane_in (start_addr[LANE_W-1:0]),
      .wr_in   (wr_in),
      .ord_in  (ord_sel),
      .base_q  (base_q),
      .lane_q  (lane_q),
      .wr_q    (wr_o),
      .ord_q   (ord_q)
   );

   burst_lane_map #(.CW(LANE_W), .ALLOW_XOR(ALLOW_XOR)) u_map (
      .start_lane (lane_q),
      .cnt        (cnt),
      .ord        (ord_q),
      .lane       (lane)
   );

   assign addr_o = {base_q, lane};
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
   parameter int ADDR_W    = 32,
   parameter int LANE_W    = 2,
   parameter bit ALLOW_XOR = 1'b1
) (
   input logic              clk,
   input logic              rst,
   input logic              stall,
   input logic              load,
   input logic              step,
   input logic [ADDR_W-1:0] start_addr,
   input logic              wr_in,
   input logic              mode_il,
   input logic [ADDR_W-1:0] addr_o,
   input logic              wr_o
);
   localparam logic [LANE_W-1:0] ONE = LANE_W'(1);

   logic [LANE_W-1:0] c_cnt;
   logic [LANE_W-1:0] c_lane;
   logic              c_xor;

   always_ff @(posedge clk) begin
      if (rst) begin
         c_cnt  <= '0;
         c_lane <= '0;
         c_xor  <= 1'b0;
      end else if (!stall && load) begin
         c_cnt  <= '0;
         c_lane <= start_addr[LANE_W-1:0];
         c_xor  <= ALLOW_XOR && mode_il;
      end else if (!stall && step) begin
         c_cnt  <= c_cnt + ONE;
      end
   end

   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (addr_o == '0 && wr_o == 1'b0)); // R1

   AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
      (!stall && load) |=> addr_o == $past(start_addr)); // R2

   AST_TYPE_LATCH: assert property (@(posedge clk) disable iff (rst)
      (!stall && load) |=> wr_o == $past(wr_in)); // R3

   AST_TYPE_KEEP: assert property (@(posedge clk) disable iff (rst)
      (!stall && !load) |=> $stable(wr_o)); // R3

   AST_LIN_NEXT: assert property (@(posedge clk) disable iff (rst)
      (!stall && !load && step && !c_xor) |=>
         addr_o[LANE_W-1:0] == LANE_W'($past(addr_o[LANE_W-1:0]) + ONE)); // R4

   AST_XOR_LANE: assert property (@(posedge clk) disable iff (rst)
      c_xor |-> addr_o[LANE_W-1:0] == (c_lane ^ c_cnt)); // R5

   AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
      (!stall && !load) |=> $stable(addr_o[ADDR_W-1:LANE_W])); // R6

   AST_FREEZE: assert property (@(posedge clk) disable iff (rst)
      stall |=> ($stable(addr_o) && $stable(wr_o))); // R7

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!stall && !load && !step) |=> $stable(addr_o)); // R8
endmodule

bind burst_addr_seq burst_addr_seq_chk #(
   .ADDR_W(ADDR_W), .LANE_W(LANE_W), .ALLOW_XOR(ALLOW_XOR)
) u_chk (.*);

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          stall = 1'b0;
   logic          load = 1'b0;
   logic          step = 1'b0;
   logic [AW-1:0] start_addr = '0;
   logic          wr_in = 1'b0;
   logic          mode_il = 1'b0;
   logic [AW-1:0] addr_o;
   logic          wr_o;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   logic [AW-1:0] q_addr[$];
   logic          q_wr[$];
   string         q_tag[$];

   // reference state built from the requirements
   logic [AW-1:0] m_start = '0;
   logic [1:0]    m_cnt = '0;
   logic          m_xor = 1'b0;
   logic          m_wr = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   burst_addr_seq u_burst_addr_seq (
      .clk(clk), .rst(rst), .stall(stall), .load(load), .step(step),
      .start_addr(start_addr), .wr_in(wr_in), .mode_il(mode_il),
      .addr_o(addr_o), .wr_o(wr_o)
   );

   function automatic logic [AW-1:0] model_addr();
      logic [1:0] ln;
      ln = m_xor ? (m_start[1:0] ^ m_cnt) : (m_start[1:0] + m_cnt);
      return {m_start[AW-1:2], ln};
   endfunction

   task automatic drive(input bit r, input bit s, input bit ld, input bit st,
                        input logic [AW-1:0] a, input bit w, input bit md,
                        input string tag);
      @(negedge clk);
      rst = r; stall = s; load = ld; step = st;
      start_addr = a; wr_in = w; mode_il = md;
      if (r) begin
         m_start = '0; m_cnt = '0; m_xor = 1'b0; m_wr = 1'b0;
      end else if (!s && ld) begin
         m_start = a; m_cnt = '0; m_xor = md; m_wr = w;
      end else if (!s && st) begin
         m_cnt = m_cnt + 2'd1;
      end
      q_addr.push_back(model_addr());
      q_wr.push_back(m_wr);
      q_tag.push_back(tag);
   endtask

   // monitor: compares each result after the edge it belongs to
   always @(posedge clk) begin
      #2;
      if (q_addr.size() > 0) begin
         logic [AW-1:0] ea;
         logic          ew;
         string         tg;
         ea = q_addr.pop_front();
         ew = q_wr.pop_front();
         tg = q_tag.pop_front();
         checks++;
         if (addr_o !== ea || wr_o !== ew) begin
            errors++;
            $display("FAIL %s: addr=%h wr=%b expected addr=%h wr=%b",
                     tg, addr_o, wr_o, ea, ew);
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      drive(1, 0, 0, 0, '0, 0, 0, "R1 reset");
      drive(1, 0, 0, 0, '0, 0, 0, "R1 reset");
      // R2 load, linear burst from lane 1 (R4), write type (R3)
      drive(0, 0, 1, 0, 32'hABCD_0121, 1, 0, "R2 load lin");
      drive(0, 0, 0, 1, '0, 0, 1, "R4 R3 R9 step1");
      drive(0, 0, 0, 1, '0, 0, 1, "R4 R9 step2");
      drive(0, 0, 0, 1, '0, 1, 0, "R4 wrap to 0");
      drive(0, 0, 0, 1, '0, 0, 1, "R6 fifth beat");
      drive(0, 0, 0, 1, '0, 0, 0, "R6 keeps cycling");
      // R7 stall with load and step
      drive(0, 1, 1, 1, 32'h1111_1113, 0, 1, "R7 stall load");
      drive(0, 1, 0, 1, '0, 0, 0, "R7 stall step");
      // R8 idle
      drive(0, 0, 0, 0, 32'h2222_2222, 0, 1, "R8 idle");
      // R5 interleaved from lane 1, read type
      drive(0, 0, 1, 0, 32'h5A5A_FF01, 0, 1, "R2 load xor");
      drive(0, 0, 0, 1, '0, 1, 0, "R5 R3 R9 beat1");
      drive(0, 0, 0, 1, '0, 1, 0, "R5 beat2");
      drive(0, 0, 0, 1, '0, 1, 1, "R5 beat3");
      drive(0, 0, 0, 1, '0, 0, 0, "R6 xor wrap");
      // R2 reload mid burst, interleaved from lane 2
      drive(0, 0, 1, 0, 32'h0000_00F6, 1, 1, "R2 reload");
      drive(0, 0, 0, 1, '0, 0, 0, "R5 lane2 b1");
      drive(0, 0, 0, 1, '0, 0, 0, "R5 lane2 b2");
      drive(0, 0, 0, 1, '0, 0, 0, "R5 lane2 b3");
      // R2 load wins over step; linear from lane 3
      drive(0, 0, 1, 1, 32'hFFFF_FFFF, 0, 0, "R2 load over step");
      drive(0, 0, 0, 1, '0, 1, 0, "R4 lane3 b1");
      drive(0, 0, 0, 1, '0, 1, 0, "R4 lane3 b2");
      drive(0, 0, 0, 1, '0, 1, 0, "R6 upper fixed");
      drive(0, 0, 0, 1, '0, 1, 0, "R6 back to start");
      // R1 reset mid burst
      drive(1, 0, 0, 1, '0, 1, 1, "R1 mid reset");
      drive(0, 0, 0, 0, '0, 0, 0, "R8 after reset");
      drive(0, 0, 0, 0, '0, 0, 0, "R8 idle2");
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule